// File: doc/BRIEF.md
# Sequential Significand Divider

This block divides one floating-point operand by another, working on operands that are already unpacked. Each operand arrives as a sign bit, a signed unbiased exponent, a significand and a class code. A normal significand is read as 1.f, with its top bit set. The block returns four things: a normalized quotient significand with guard and round bits, the adjusted exponent, the result sign and a sticky bit. It also returns a result class and two exception flags, invalid and divide-by-zero. Rounding and packing are left to a later stage.

A special-operand decision table checks both classes on the start cycle. NaN, zero and infinity cases are settled there and reported on the next cycle. When both operands are normal, the block runs a radix-2 restoring loop that makes one quotient bit per clock. The first trial subtraction runs in the start cycle. It settles the leading quotient bit and decides whether the exponent needs a decrement. Every later step shifts the partial remainder left and keeps the difference R - Y only when the borrow shows it is non-negative.

The caller pulses `start` while `busy` is low and waits for the one-cycle `done` pulse. The result outputs hold their values until the next accepted start.

Top module: `seq_sig_div`

## Requirements
- R1: Class codes are zero=0, normal=1, infinity=2, quiet NaN=3, signalling NaN=4. If either operand is a NaN, the result is the operand with the larger class code, or the divisor when the codes are equal. Its sign, class and sign-extended exponent are returned, and the quotient is its significand followed by GR_W zero bits. Both flags stay 0.
- R2: Infinity over infinity and zero over zero give class quiet NaN with sign 0, exponent 0, a quotient of all ones, and flag_inv=1.
- R3: An infinite or zero dividend over a non-NaN divisor of a different class returns the dividend unchanged. Its own sign, class and exponent are returned, the quotient is its significand followed by GR_W zero bits, and both flags are 0.
- R4: A normal dividend over an infinite divisor gives class zero. A normal dividend over a zero divisor gives class infinity with flag_dz=1. In both cases the exponent and quotient are 0 and the sign is the XOR of the operand signs.
- R5: For two normal operands, let the dividend significand be X and the divisor significand be Y.
  - When X >= Y, the quotient is floor(X·2^(QW-1)/Y) and the exponent is x_exp - y_exp.
  - Otherwise the quotient is floor(X·2^QW/Y) and the exponent is x_exp - y_exp - 1.
  - QW = SIG_W + GR_W, and the quotient's top bit is always 1.
- R6: For two normal operands, res_sticky is 1 exactly when the division leaves a nonzero remainder.
- R7: For two normal operands, res_sign is the XOR of the operand signs and the flags are 0.
- R8: `done` is high for one cycle, on the cycle after start is sampled for a special case and QW cycles after for two normal operands. `busy` is high in between and low whenever `done` is high.
- R9: A start pulse while busy is ignored: the running result is unaffected and no extra `done` appears.
- R10: After reset, busy and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a division (taken only when not busy) |
| x_sign | input | 1 | Dividend sign |
| x_exp | input | EXP_W | Dividend exponent, signed, unbiased |
| x_sig | input | SIG_W | Dividend significand (1.f when normal) |
| x_cls | input | 3 | Dividend class code |
| y_sign | input | 1 | Divisor sign |
| y_exp | input | EXP_W | Divisor exponent, signed, unbiased |
| y_sig | input | SIG_W | Divisor significand (1.f when normal) |
| y_cls | input | 3 | Divisor class code |
| busy | output | 1 | Quotient loop running |
| done | output | 1 | One-cycle result-valid pulse |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W+2 | Result exponent, signed |
| res_quo | output | SIG_W+GR_W | Quotient significand with guard and round bits |
| res_sticky | output | 1 | OR of the bits below the round bit |
| res_cls | output | 3 | Result class code |
| flag_inv | output | 1 | Invalid-operation flag |
| flag_dz | output | 1 | Divide-by-zero flag |

## Verification
Some properties are checked on every cycle by the assertions:
- the partial remainder stays below the divisor on every loop step;
- a finished normal quotient has its top bit set;
- an invalid flag only comes with a quiet NaN, and a divide-by-zero flag only with infinity;
- done and busy are never high together;
- a start seen while busy leaves the captured exponent unchanged.

The bench scenarios are needed for everything else. They cover the exact quotient and sticky values, the exponent decrement when X < Y, and the order in which NaN operands are preferred. They also check each special-case payload and the exact cycle on which done rises.

// File: rtl/sdiv_pkg.sv
// Package: shared operand class codes and special-result selector for the
// sequential significand divider. Codes are fixed because callers encode them.
package sdiv_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NORM = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } opclass_e;

    typedef enum logic [1:0] {
        PICK_X    = 2'd0,
        PICK_Y    = 2'd1,
        PICK_NONE = 2'd2
    } pick_e;

endpackage

// File: rtl/sdiv_special.sv
// Module: sdiv_special
// Combinational decision table for non-normal operand pairs. Decides whether
// the division is a special case, which operand (if any) supplies the
// payload, the result class and sign, and the exception flags.
// Assumes: class codes outside the enum are not presented.
module sdiv_special
    import sdiv_pkg::*;
(
    input  opclass_e x_cls,
    input  opclass_e y_cls,
    input  logic     x_sign,
    input  logic     y_sign,
    output logic     special,
    output opclass_e cls,
    output logic     sign,
    output pick_e    pick,
    output logic     inv,
    output logic     dz
);

    logic x_nan, y_nan, x_edge;

    assign x_nan  = (x_cls == CLS_QNAN) || (x_cls == CLS_SNAN);
    assign y_nan  = (y_cls == CLS_QNAN) || (y_cls == CLS_SNAN);
    assign x_edge = (x_cls == CLS_INF)  || (x_cls == CLS_ZERO);

    // Priority-ordered case table: NaN, odd dividend, odd divisor, normal.
    always_comb begin
        special = 1'b0;
        cls     = CLS_NORM;
        sign    = x_sign ^ y_sign;
        pick    = PICK_NONE;
        inv     = 1'b0;
        dz      = 1'b0;
        if (x_nan || y_nan) begin
            special = 1'b1;
            if (x_cls > y_cls) begin
                pick = PICK_X;
                cls  = x_cls;
                sign = x_sign;
            end else begin
                pick = PICK_Y;
                cls  = y_cls;
                sign = y_sign;
            end
        end else if (x_edge) begin
            special = 1'b1;
            if (x_cls == y_cls) begin
                cls  = CLS_QNAN;
                sign = 1'b0;
                inv  = 1'b1;
            end else begin
                pick = PICK_X;
                cls  = x_cls;
                sign = x_sign;
            end
        end else if (y_cls == CLS_INF) begin
            special = 1'b1;
            cls     = CLS_ZERO;
        end else if (y_cls == CLS_ZERO) begin
            special = 1'b1;
            cls     = CLS_INF;
            dz      = 1'b1;
        end
    end

endmodule

// File: rtl/sdiv_core.sv
// Module: sdiv_core
// Radix-2 restoring divider datapath for normalized significands. On load it
// does the up-front trial X - Y; if negative it starts from 2X - Y instead,
// so the leading quotient bit is always 1. Each step shifts R left, trials
// R - Y and keeps the difference when its borrow is clear. Quotient bits
// shift in from the right, most significant first.
// Assumes: x_sig and y_sig have their top bit set when load is asserted.
module sdiv_core #(
    parameter int SIG_W = 24,
    parameter int QW    = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [SIG_W-1:0] x_sig,
    input  logic [SIG_W-1:0] y_sig,
    output logic             lead_ge,
    output logic [QW-1:0]    quo,
    output logic             rem_nz
);

    localparam int RW = SIG_W + 1;

    logic [RW-1:0]    rem_q;
    logic [SIG_W-1:0] y_q;
    logic [QW-1:0]    quo_q;
    logic [RW:0]      d_once;
    logic [RW-1:0]    d_twice;
    logic [RW:0]      shifted;
    logic [RW+1:0]    trial;
    logic             keep;
    logic             unused_bits;

    assign d_once      = {2'b00, x_sig} - {2'b00, y_sig};
    assign d_twice     = {x_sig, 1'b0} - {1'b0, y_sig};
    assign lead_ge     = ~d_once[RW];
    assign shifted     = {rem_q, 1'b0};
    assign trial       = {1'b0, shifted} - {3'b000, y_q};
    assign keep        = ~trial[RW+1];
    assign unused_bits = trial[RW] ^ shifted[RW];

    // Remainder, divisor and quotient registers: setup on load, one bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            y_q   <= '0;
            quo_q <= '0;
        end else if (load) begin
            y_q   <= y_sig;
            rem_q <= lead_ge ? d_once[RW-1:0] : d_twice;
            quo_q <= QW'(1);
        end else if (step) begin
            rem_q <= keep ? trial[RW-1:0] : shifted[RW-1:0];
            quo_q <= {quo_q[QW-2:0], keep};
        end
    end

    assign quo    = quo_q;
    assign rem_nz = |rem_q;

    // R5: restoring invariant, the partial remainder never reaches the divisor.
    a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rem_q < {1'b0, y_q}));

endmodule

// File: rtl/seq_sig_div.sv
// Module: seq_sig_div (top)
// Sequential significand divider with start/busy/done handshake. The start
// cycle resolves special operands through sdiv_special, or loads sdiv_core
// and the exponent for a normal pair; then QW-1 loop cycles follow.
// Assumes: exponents are signed and unbiased; normal significands are 1.f.
module seq_sig_div
    import sdiv_pkg::*;
#(
    parameter int SIG_W = 24,
    parameter int EXP_W = 10,
    parameter int GR_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          x_sign,
    input  logic signed [EXP_W-1:0]       x_exp,
    input  logic [SIG_W-1:0]              x_sig,
    input  logic [2:0]                    x_cls,
    input  logic                          y_sign,
    input  logic signed [EXP_W-1:0]       y_exp,
    input  logic [SIG_W-1:0]              y_sig,
    input  logic [2:0]                    y_cls,
    output logic                          busy,
    output logic                          done,
    output logic                          res_sign,
    output logic signed [EXP_W+1:0]       res_exp,
    output logic [SIG_W+GR_W-1:0]         res_quo,
    output logic                          res_sticky,
    output logic [2:0]                    res_cls,
    output logic                          flag_inv,
    output logic                          flag_dz
);

    localparam int QW     = SIG_W + GR_W;
    localparam int OEXP_W = EXP_W + 2;
    localparam int CNT_W  = $clog2(QW);

    opclass_e                 xc, yc, sp_cls, cls_q;
    pick_e                    sp_pick;
    logic                     sp_special, sp_sign, sp_inv, sp_dz;
    logic                     lead_ge, rem_nz, accept;
    logic [QW-1:0]            core_quo, sp_quo, spec_quo_q;
    logic signed [OEXP_W-1:0] x_exp_w, y_exp_w, exp_diff, sp_exp, exp_q;
    logic                     run_q, done_q, sign_q, inv_q, dz_q;
    logic [CNT_W-1:0]         cnt_q;

    assign xc      = opclass_e'(x_cls);
    assign yc      = opclass_e'(y_cls);
    assign accept  = start && !run_q;
    assign x_exp_w = {{2{x_exp[EXP_W-1]}}, x_exp};
    assign y_exp_w = {{2{y_exp[EXP_W-1]}}, y_exp};
    assign exp_diff = x_exp_w - y_exp_w;

    sdiv_special u_special (
        .x_cls   (xc),
        .y_cls   (yc),
        .x_sign  (x_sign),
        .y_sign  (y_sign),
        .special (sp_special),
        .cls     (sp_cls),
        .sign    (sp_sign),
        .pick    (sp_pick),
        .inv     (sp_inv),
        .dz      (sp_dz)
    );

    sdiv_core #(.SIG_W(SIG_W), .QW(QW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept && !sp_special),
        .step    (run_q),
        .x_sig   (x_sig),
        .y_sig   (y_sig),
        .lead_ge (lead_ge),
        .quo     (core_quo),
        .rem_nz  (rem_nz)
    );

    // Special-result payload: chosen operand's exponent and significand, else fixed values.
    always_comb begin
        case (sp_pick)
            PICK_X:  begin sp_exp = x_exp_w; sp_quo = {x_sig, {GR_W{1'b0}}}; end
            PICK_Y:  begin sp_exp = y_exp_w; sp_quo = {y_sig, {GR_W{1'b0}}}; end
            default: begin sp_exp = '0;      sp_quo = sp_inv ? '1 : '0;      end
        endcase
    end

    // Handshake sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            done_q     <= 1'b0;
            cnt_q      <= '0;
            sign_q     <= 1'b0;
            exp_q      <= '0;
            spec_quo_q <= '0;
            cls_q      <= CLS_ZERO;
            inv_q      <= 1'b0;
            dz_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                sign_q <= sp_sign;
                cls_q  <= sp_cls;
                inv_q  <= sp_inv;
                dz_q   <= sp_dz;
                if (sp_special) begin
                    done_q     <= 1'b1;
                    exp_q      <= sp_exp;
                    spec_quo_q <= sp_quo;
                end else begin
                    run_q <= 1'b1;
                    cnt_q <= CNT_W'(QW - 1);
                    exp_q <= lead_ge ? exp_diff : exp_diff - OEXP_W'(1);
                end
            end else if (run_q) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy       = run_q;
    assign done       = done_q;
    assign res_sign   = sign_q;
    assign res_exp    = exp_q;
    assign res_cls    = cls_q;
    assign res_quo    = (cls_q == CLS_NORM) ? core_quo : spec_quo_q;
    assign res_sticky = (cls_q == CLS_NORM) && rem_nz;
    assign flag_inv   = inv_q;
    assign flag_dz    = dz_q;

    // R10: outputs idle in the first cycle after reset is released.
    a_r10_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !done));

    // R8: a result is never reported while the loop is still running.
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: a start seen while busy does not disturb the captured exponent.
    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(res_exp));

    // R5: a finished normal quotient is normalized.
    a_r5_leading_one: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_cls == CLS_NORM) |-> res_quo[QW-1]);

    // R2: invalid flag only accompanies a generated quiet NaN.
    a_r2_inv_is_qnan: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_inv) |-> (res_cls == CLS_QNAN));

    // R4: divide-by-zero flag only accompanies an infinite result.
    a_r4_dz_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_dz) |-> (res_cls == CLS_INF));

endmodule

// File: tb/seq_sig_div_tb_top.sv
// Scoreboard bench: launch() computes the expected result from the
// requirements and queues it; the monitor pops on every done and compares.
module seq_sig_div_tb_top;

    localparam int SIG_W = 24;
    localparam int EXP_W = 10;
    localparam int GR_W  = 2;
    localparam int QW    = SIG_W + GR_W;
    localparam int OEXP_W = EXP_W + 2;
    localparam int C_ZERO = 0, C_NORM = 1, C_INF = 2, C_QNAN = 3, C_SNAN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic x_sign = 1'b0, y_sign = 1'b0;
    logic signed [EXP_W-1:0] x_exp = '0, y_exp = '0;
    logic [SIG_W-1:0] x_sig = '0, y_sig = '0;
    logic [2:0] x_cls = '0, y_cls = '0;
    logic busy, done, res_sign, res_sticky, flag_inv, flag_dz;
    logic signed [OEXP_W-1:0] res_exp;
    logic [QW-1:0] res_quo;
    logic [2:0] res_cls;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int spurious = 0;

    typedef struct {
        int      cls;
        bit      sign;
        int      ex;
        longint  quo;
        bit      st;
        bit      inv;
        bit      dz;
        int      lat;
        int      scyc;
        bit      norm;
        string   tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    seq_sig_div #(.SIG_W(SIG_W), .EXP_W(EXP_W), .GR_W(GR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_sign(x_sign), .x_exp(x_exp), .x_sig(x_sig), .x_cls(x_cls),
        .y_sign(y_sign), .y_exp(y_exp), .y_sig(y_sig), .y_cls(y_cls),
        .busy(busy), .done(done), .res_sign(res_sign), .res_exp(res_exp),
        .res_quo(res_quo), .res_sticky(res_sticky), .res_cls(res_cls),
        .flag_inv(flag_inv), .flag_dz(flag_dz)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
        end
    endtask

    // Monitor: compare each reported result with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                spurious++;
            end else begin
                exp_t e;
                logic [OEXP_W-1:0] ee;
                e = sb.pop_front();
                ee = e.ex[OEXP_W-1:0];
                chk(res_cls == e.cls[2:0], e.tag, "class", res_cls, e.cls);
                chk(res_exp == ee, e.norm ? "R5" : e.tag, "exponent", res_exp, ee);
                chk({38'd0, res_quo} == e.quo, e.norm ? "R5" : e.tag, "quotient", res_quo, e.quo);
                chk(res_sign == e.sign, e.norm ? "R7" : e.tag, "sign", res_sign, e.sign);
                chk(res_sticky == e.st, e.norm ? "R6" : e.tag, "sticky", res_sticky, e.st);
                chk(flag_inv == e.inv && flag_dz == e.dz, e.norm ? "R7" : e.tag, "flags",
                    {flag_inv, flag_dz}, {e.inv, e.dz});
                chk(cyc - e.scyc == e.lat, "R8", "latency", cyc - e.scyc, e.lat);
            end
        end
    end

    // Driver: model the expected result, queue it, and pulse start.
    task automatic launch(input int xc, input bit xs, input int xe, input logic [SIG_W-1:0] xm,
                          input int yc, input bit ys, input int ye, input logic [SIG_W-1:0] ym,
                          input string tag);
        exp_t e;
        longint num;
        e.inv = 0; e.dz = 0; e.st = 0; e.lat = 1; e.norm = 0; e.tag = tag;
        if (xc >= C_QNAN || yc >= C_QNAN) begin
            if (xc > yc) begin
                e.cls = xc; e.sign = xs; e.ex = xe; e.quo = longint'(xm) << GR_W;
            end else begin
                e.cls = yc; e.sign = ys; e.ex = ye; e.quo = longint'(ym) << GR_W;
            end
        end else if (xc == C_INF || xc == C_ZERO) begin
            if (xc == yc) begin
                e.cls = C_QNAN; e.sign = 0; e.ex = 0; e.quo = (longint'(1) << QW) - 1; e.inv = 1;
            end else begin
                e.cls = xc; e.sign = xs; e.ex = xe; e.quo = longint'(xm) << GR_W;
            end
        end else if (yc == C_INF) begin
            e.cls = C_ZERO; e.sign = xs ^ ys; e.ex = 0; e.quo = 0;
        end else if (yc == C_ZERO) begin
            e.cls = C_INF; e.sign = xs ^ ys; e.ex = 0; e.quo = 0; e.dz = 1;
        end else begin
            e.cls = C_NORM; e.sign = xs ^ ys; e.lat = QW; e.norm = 1;
            if (xm >= ym) begin
                num = longint'(xm) << (QW - 1); e.ex = xe - ye;
            end else begin
                num = longint'(xm) << QW; e.ex = xe - ye - 1;
            end
            e.quo = num / longint'(ym);
            e.st = (num % longint'(ym)) != 0;
        end
        @(negedge clk);
        e.scyc = cyc;
        sb.push_back(e);
        x_cls = xc[2:0]; x_sign = xs; x_exp = xe[EXP_W-1:0]; x_sig = xm;
        y_cls = yc[2:0]; y_sign = ys; y_exp = ye[EXP_W-1:0]; y_sig = ym;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic op(input int xc, input bit xs, input int xe, input logic [SIG_W-1:0] xm,
                      input int yc, input bit ys, input int ye, input logic [SIG_W-1:0] ym,
                      input string tag);
        launch(xc, xs, xe, xm, yc, ys, ye, ym, tag);
        drain();
    endtask

    localparam logic [SIG_W-1:0] ONE = 24'h800000;

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'h1d2c3b4a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R10", "busy/done after reset", {busy, done}, 0);

        // R1: NaN selection order
        op(C_SNAN, 1, 5, 24'hC12345, C_QNAN, 0, 7, 24'hE00001, "R1");
        op(C_QNAN, 0, 3, 24'hC00001, C_SNAN, 1, -2, 24'hA00002, "R1");
        op(C_QNAN, 1, 9, 24'hC00003, C_QNAN, 0, 4, 24'hD00004, "R1");
        op(C_QNAN, 1, 9, 24'hC00005, C_NORM, 0, 4, ONE, "R1");
        op(C_ZERO, 0, 1, 24'h000000, C_SNAN, 1, 2, 24'hB00006, "R1");
        // R2: generated NaN
        op(C_INF, 1, 0, 24'h0, C_INF, 0, 0, 24'h0, "R2");
        op(C_ZERO, 1, 0, 24'h0, C_ZERO, 1, 0, 24'h0, "R2");
        // R3: dividend pass-through
        op(C_INF, 1, 11, 24'h123456, C_NORM, 0, 3, ONE, "R3");
        op(C_INF, 0, -4, 24'h000001, C_ZERO, 1, 0, 24'h0, "R3");
        op(C_ZERO, 1, 2, 24'h000000, C_INF, 0, 0, 24'h0, "R3");
        op(C_ZERO, 0, -7, 24'h000010, C_NORM, 1, 5, 24'hC00000, "R3");
        // R4: generated zero and infinity
        op(C_NORM, 1, 6, 24'hC00000, C_INF, 0, 1, 24'h0, "R4");
        op(C_NORM, 0, 6, 24'hC00000, C_ZERO, 1, 1, 24'h0, "R4");
        // R5/R6/R7: normal divisions, including X>=Y, X<Y, X==Y and extremes
        op(C_NORM, 0, 3, 24'hC00000, C_NORM, 0, 1, ONE, "R5");
        op(C_NORM, 1, 3, ONE, C_NORM, 0, 1, 24'hC00000, "R5");
        op(C_NORM, 1, -5, 24'hA00000, C_NORM, 1, 7, 24'hA00000, "R5");
        op(C_NORM, 0, 100, 24'hFFFFFF, C_NORM, 1, -100, 24'h800001, "R6");
        op(C_NORM, 0, -200, ONE, C_NORM, 0, 200, 24'hFFFFFF, "R6");
        for (int i = 0; i < 8; i++) begin
            logic [SIG_W-1:0] a, b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = ONE | SIG_W'(lfsr[22:0]);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = ONE | SIG_W'(lfsr[24:2]);
            op(C_NORM, lfsr[3], i * 13 - 40, a, C_NORM, lfsr[9], 20 - i * 7, b, "R5");
        end

        // R9: start while busy is ignored
        launch(C_NORM, 0, 2, 24'hB00000, C_NORM, 1, 0, 24'h900000, "R9");
        repeat (4) @(negedge clk);
        chk(busy == 1'b1, "R8", "busy during loop", busy, 1);
        x_cls = 3'(C_QNAN); y_cls = 3'(C_ZERO); x_exp = 10'sd77; x_sig = 24'hFFFFFF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain();
        repeat (QW + 4) @(negedge clk);
        chk(spurious == 0, "R9", "unexpected done count", spurious, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R8 watchdog act=%0d exp=%0d", sb.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule